// File: doc/BRIEF.md
# Audio Sample Rate Pacer

This block sits between software and a pair of audio sample FIFOs, one feeding a stereo DAC and one draining a stereo ADC. It paces each path by turning a single-cycle 96 kHz base tick into transfer strobes. Each path has a divider of its own, so its rate is 96 kHz / (n+1). It also compares each FIFO's fill level against a programmable threshold and raises an interrupt. For the DAC this happens when the FIFO is running dry. For the ADC it happens when the FIFO is filling up.

Software reaches the block through a small word-wide write port and a read port. Path enables and rate dividers are not separate registers. Each setting is written through one control word that carries an 8-bit internal address in its upper byte and an 8-bit value in its lower byte. Samples are 24 bits per channel and are carried as two words: a 16-bit high word and a low word whose lower byte holds the remaining 8 bits.

- For the DAC, software writes four words. The write of the right-channel low word hands the whole stereo sample to the FIFO.
- For the ADC, a write to the pop register takes one stereo sample from the FIFO. That sample becomes readable as four words.

Top module: `audio_pacer`

## Requirements
- R1: A write to select 4 is a control word: bits 15..8 are an internal address and bits 7..0 its value. Address 1 bit 0 enables the DAC path and address 3 bit 0 enables the ADC path. Address 0, and any address other than 1..4, changes nothing.
- R2: Control address 2 (DAC) and address 4 (ADC) hold a 4-bit divider n in bits 3..0. An enabled path pulses its strobe for one cycle on every (n+1)-th tick, counting from the moment it was enabled. The pulse comes one cycle after that tick.
- R3: A disabled path gives no strobe and holds its interrupt low, whatever the FIFO level.
- R4: Select 5 bits 7..0 set the DAC threshold. When the DAC path is enabled, the DAC interrupt is high one cycle after the DAC level is strictly below that threshold, and low otherwise.
- R5: Select 6 bits 7..0 set the ADC threshold. When the ADC path is enabled, the ADC interrupt is high one cycle after the ADC level is strictly above that threshold, and low otherwise.
- R6: The DAC sample is written through these selects:
  - select 0: left high word, sample bits 23..8;
  - select 1: left low word, bits 7..0 of the written word;
  - select 2: right high word;
  - select 3: right low word.
  
  The write to select 3 pulses the commit output for one cycle in the next cycle, with the sample output set to {left[23:0], right[23:0]}. Writes to selects 0..2 never commit.
- R7: A write to select 7 pulses the pop output in the next cycle. The sample the FIFO returns one cycle after pop (in {left, right} layout) is readable from the second cycle after the write onward. Read selects are: 0 for left bits 23..8, 1 for left bits 7..0 in the lower byte with the upper byte zero, 2 for right bits 23..8, and 3 for right bits 7..0.
- R8: After reset both paths are disabled, every strobe, interrupt, commit and pop output is low, and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle 96 kHz base tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write register select |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | ADC sample word select |
| rd_data_o | output | 16 | ADC sample word |
| dac_level_i | input | 8 | DAC FIFO fill level |
| adc_level_i | input | 8 | ADC FIFO fill level |
| dac_strobe_o | output | 1 | DAC transfer pacing strobe |
| adc_strobe_o | output | 1 | ADC transfer pacing strobe |
| dac_irq_o | output | 1 | DAC FIFO low interrupt |
| adc_irq_o | output | 1 | ADC FIFO high interrupt |
| dac_commit_o | output | 1 | Push of a stereo sample into the DAC FIFO |
| dac_sample_o | output | 48 | Committed stereo sample {left, right} |
| adc_pop_o | output | 1 | Pop request to the ADC FIFO |
| adc_sample_i | input | 48 | ADC FIFO head sample {left, right} |

## Verification
The pacing dividers are driven with runs of ticks at n = 0, 1, 2 and 15 on the DAC and n = 3 on the ADC. The run lengths are chosen so that floor(ticks/(n+1)) differs between neighbouring n, which exposes off-by-one counting. The threshold compares are tried one below, exactly at and one above each threshold, which separates a strict compare from an inclusive one and a below-threshold rule from an above-threshold rule. The same levels are then repeated with the path disabled. A queue-based scoreboard expects one commit per completed four-word DAC sample. It uses distinct left and right patterns, so swapped channels or misplaced low bytes show up. ADC pops are read back one cycle early and on time to pin down the two-cycle latency.

// File: rtl/audio_pacer_pkg.sv
package audio_pacer_pkg;
  localparam int unsigned DIV_W = 4;

  typedef enum logic [2:0] {
    WR_DAC_LH  = 3'd0,
    WR_DAC_LL  = 3'd1,
    WR_DAC_RH  = 3'd2,
    WR_DAC_RL  = 3'd3,
    WR_CTRL    = 3'd4,
    WR_DAC_THR = 3'd5,
    WR_ADC_THR = 3'd6,
    WR_ADC_POP = 3'd7
  } wr_sel_e;

  typedef enum logic [7:0] {
    CFG_NONE    = 8'd0,
    CFG_DAC_EN  = 8'd1,
    CFG_DAC_DIV = 8'd2,
    CFG_ADC_EN  = 8'd3,
    CFG_ADC_DIV = 8'd4
  } cfg_addr_e;

  typedef struct packed {
    logic             dac_en;
    logic [DIV_W-1:0] dac_div;
    logic             adc_en;
    logic [DIV_W-1:0] adc_div;
  } cfg_t;
endpackage

// File: rtl/audio_cfg_regs.sv
module audio_cfg_regs
  import audio_pacer_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [15:0]      wr_data_i,
  output cfg_t             cfg_o,
  output logic [LVL_W-1:0] dac_thr_o,
  output logic [LVL_W-1:0] adc_thr_o
);
  cfg_t             cfg_q;
  logic [LVL_W-1:0] dac_thr_q, adc_thr_q;
  logic [7:0]       c_addr, c_data;

  assign c_addr = wr_data_i[15:8];
  assign c_data = wr_data_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      dac_thr_q <= '0;
      adc_thr_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        WR_CTRL: begin
          case (c_addr)
            CFG_DAC_EN:  cfg_q.dac_en  <= c_data[0];
            CFG_DAC_DIV: cfg_q.dac_div <= c_data[DIV_W-1:0];
            CFG_ADC_EN:  cfg_q.adc_en  <= c_data[0];
            CFG_ADC_DIV: cfg_q.adc_div <= c_data[DIV_W-1:0];
            default: ;
          endcase
        end
        WR_DAC_THR: dac_thr_q <= wr_data_i[LVL_W-1:0];
        WR_ADC_THR: adc_thr_q <= wr_data_i[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o     = cfg_q;
  assign dac_thr_o = dac_thr_q;
  assign adc_thr_o = adc_thr_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == WR_CTRL) |=> $stable(cfg_q)) // R1
    else $error("cfg changed without control write");
endmodule

// File: rtl/audio_rate_div.sv
module audio_rate_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        // >= so a divider lowered mid-count wraps at once
        if (cnt_q >= div_i) begin
          cnt_q    <= '0;
          strobe_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign strobe_o = strobe_q;

  AST_STROBE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(tick_i && en_i)) // R2
    else $error("strobe without tick");
  AST_NO_STROBE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !strobe_o) // R3
    else $error("strobe on disabled path");
endmodule

// File: rtl/audio_level_cmp.sv
module audio_level_cmp #(
  parameter int unsigned LVL_W = 8,
  parameter bit          ABOVE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             irq_o
);
  logic hit, irq_q;

  generate
    if (ABOVE) begin : g_above
      assign hit = level_i > thr_i;
    end else begin : g_below
      assign hit = level_i < thr_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i && hit;
  end

  assign irq_o = irq_q;

  AST_IRQ_OFF_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o) // R3
    else $error("irq on disabled path");
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_i)) // R4, R5
    else $error("irq without enable");
endmodule

// File: rtl/audio_dac_pack.sv
module audio_dac_pack
  import audio_pacer_pkg::*;
#(
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned WORD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic               commit_o,
  output logic [2*SMP_W-1:0] sample_o
);
  localparam int unsigned LO_W = SMP_W - WORD_W;

  logic [WORD_W-1:0]  lh_q, rh_q;
  logic [LO_W-1:0]    ll_q;
  logic               commit_q;
  logic [2*SMP_W-1:0] sample_q;
  logic               is_rl;

  assign is_rl = wr_en_i && (wr_sel_i == WR_DAC_RL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lh_q     <= '0;
      ll_q     <= '0;
      rh_q     <= '0;
      commit_q <= 1'b0;
      sample_q <= '0;
    end else begin
      commit_q <= is_rl;
      if (wr_en_i) begin
        case (wr_sel_i)
          WR_DAC_LH: lh_q <= wr_data_i;
          WR_DAC_LL: ll_q <= wr_data_i[LO_W-1:0];
          WR_DAC_RH: rh_q <= wr_data_i;
          default: ;
        endcase
      end
      if (is_rl) sample_q <= {lh_q, ll_q, rh_q, wr_data_i[LO_W-1:0]};
    end
  end

  assign commit_o = commit_q;
  assign sample_o = sample_q;

  AST_COMMIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_en_i && wr_sel_i == WR_DAC_RL)) // R6
    else $error("commit without right-low write");
  AST_SAMPLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> $stable(sample_o)) // R6
    else $error("sample changed without commit");
endmodule

// File: rtl/audio_adc_unpack.sv
module audio_adc_unpack #(
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned WORD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pop_req_i,
  input  logic [1:0]         rd_sel_i,
  input  logic [2*SMP_W-1:0] sample_i,
  output logic               pop_o,
  output logic [WORD_W-1:0]  rd_data_o
);
  localparam int unsigned LO_W = SMP_W - WORD_W;

  logic               pop_q, cap_q;
  logic [2*SMP_W-1:0] hold_q;
  logic [SMP_W-1:0]   left, right;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_q  <= 1'b0;
      cap_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      pop_q <= pop_req_i;
      cap_q <= pop_q;  // FIFO returns data one cycle after pop
      if (cap_q) hold_q <= sample_i;
    end
  end

  assign left  = hold_q[2*SMP_W-1:SMP_W];
  assign right = hold_q[SMP_W-1:0];

  always_comb begin
    unique case (rd_sel_i)
      2'd0: rd_data_o = left[SMP_W-1:LO_W];
      2'd1: rd_data_o = {{(WORD_W-LO_W){1'b0}}, left[LO_W-1:0]};
      2'd2: rd_data_o = right[SMP_W-1:LO_W];
      default: rd_data_o = {{(WORD_W-LO_W){1'b0}}, right[LO_W-1:0]};
    endcase
  end

  assign pop_o = pop_q;

  AST_POP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_i |=> pop_o) // R7
    else $error("pop missing");
  AST_HOLD_ONLY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pop_o) |=> $stable(hold_q)) // R7
    else $error("held sample changed without pop");
endmodule

// File: rtl/audio_pacer.sv
module audio_pacer
  import audio_pacer_pkg::*;
#(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned WORD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [1:0]         rd_sel_i,
  output logic [WORD_W-1:0]  rd_data_o,
  input  logic [LVL_W-1:0]   dac_level_i,
  input  logic [LVL_W-1:0]   adc_level_i,
  output logic               dac_strobe_o,
  output logic               adc_strobe_o,
  output logic               dac_irq_o,
  output logic               adc_irq_o,
  output logic               dac_commit_o,
  output logic [2*SMP_W-1:0] dac_sample_o,
  output logic               adc_pop_o,
  input  logic [2*SMP_W-1:0] adc_sample_i
);
  localparam int unsigned NPATH = 2;  // 0 = DAC, 1 = ADC

  cfg_t             cfg;
  logic [LVL_W-1:0] dac_thr, adc_thr;
  logic             path_en  [NPATH];
  logic [DIV_W-1:0] path_div [NPATH];
  logic [LVL_W-1:0] path_lvl [NPATH];
  logic [LVL_W-1:0] path_thr [NPATH];
  logic             path_stb [NPATH];
  logic             path_irq [NPATH];

  audio_cfg_regs #(.LVL_W(LVL_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .cfg_o(cfg), .dac_thr_o(dac_thr), .adc_thr_o(adc_thr)
  );

  assign path_en[0]  = cfg.dac_en;
  assign path_en[1]  = cfg.adc_en;
  assign path_div[0] = cfg.dac_div;
  assign path_div[1] = cfg.adc_div;
  assign path_lvl[0] = dac_level_i;
  assign path_lvl[1] = adc_level_i;
  assign path_thr[0] = dac_thr;
  assign path_thr[1] = adc_thr;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    audio_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk_i, .rst_ni, .tick_i,
      .en_i(path_en[g]), .div_i(path_div[g]), .strobe_o(path_stb[g])
    );
    audio_level_cmp #(.LVL_W(LVL_W), .ABOVE(g == 1)) u_cmp (
      .clk_i, .rst_ni,
      .en_i(path_en[g]), .level_i(path_lvl[g]), .thr_i(path_thr[g]),
      .irq_o(path_irq[g])
    );
  end

  assign dac_strobe_o = path_stb[0];
  assign adc_strobe_o = path_stb[1];
  assign dac_irq_o    = path_irq[0];
  assign adc_irq_o    = path_irq[1];

  audio_dac_pack #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_dac (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .commit_o(dac_commit_o), .sample_o(dac_sample_o)
  );

  audio_adc_unpack #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_adc (
    .clk_i, .rst_ni,
    .pop_req_i(wr_en_i && wr_sel_i == WR_ADC_POP),
    .rd_sel_i, .sample_i(adc_sample_i),
    .pop_o(adc_pop_o), .rd_data_o
  );

  AST_PATHS_QUIET_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !(dac_strobe_o || adc_strobe_o || dac_irq_o || adc_irq_o)) // R8
    else $error("outputs active after reset");
endmodule

// File: tb/audio_pacer_bench.sv
`timescale 1ns/1ps
module audio_pacer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [7:0]  dac_level = '0, adc_level = '0;
  logic        dac_strobe, adc_strobe, dac_irq, adc_irq, dac_commit, adc_pop;
  logic [47:0] dac_sample;
  logic [47:0] adc_sample = '0;

  int n_chk = 0, n_fail = 0;
  int dac_stb_cnt = 0, adc_stb_cnt = 0;
  int adc_idx = 0;
  bit done = 1'b0;
  logic [47:0] exp_q[$];

  always #10 clk = ~clk;

  audio_pacer u_audio_pacer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .dac_level_i(dac_level), .adc_level_i(adc_level),
    .dac_strobe_o(dac_strobe), .adc_strobe_o(adc_strobe),
    .dac_irq_o(dac_irq), .adc_irq_o(adc_irq),
    .dac_commit_o(dac_commit), .dac_sample_o(dac_sample),
    .adc_pop_o(adc_pop), .adc_sample_i(adc_sample)
  );

  function automatic logic [47:0] adc_model(int k);
    logic [23:0] l, r;
    l = 24'hA1B2C3 ^ (24'(k) * 24'h010203);
    r = 24'h3C2B1A + (24'(k) * 24'h000F11);
    return {l, r};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ctrl(logic [7:0] a, logic [7:0] d);
    wr(3'd4, {a, d});
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  // scoreboard driver: push expected sample before the committing write
  task automatic dac_send(logic [23:0] l, logic [23:0] r);
    wr(3'd0, l[23:8]);
    wr(3'd1, {8'h00, l[7:0]});
    wr(3'd2, r[23:8]);
    exp_q.push_back({l, r});
    wr(3'd3, {8'h00, r[7:0]});
  endtask

  task automatic dac_rate(logic [3:0] n, int k, int expect_cnt);
    int base;
    ctrl(8'd1, 8'd0);
    ctrl(8'd2, {4'h0, n});
    ctrl(8'd1, 8'd1);
    base = dac_stb_cnt;
    ticks(k);
    chk($sformatf("R2 dac n=%0d", n), 64'(dac_stb_cnt - base), 64'(expect_cnt));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_strobe) dac_stb_cnt++;
      if (adc_strobe) adc_stb_cnt++;
      if (dac_commit) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected commit", 64'(dac_sample), 64'h0);
          if (dac_sample == '0) begin
            n_fail++;
            $display("FAIL R6 commit with empty queue actual=1 expected=0");
          end
        end else begin
          chk("R6 dac sample", 64'(dac_sample), 64'(exp_q.pop_front()));
        end
      end
    end
  end

  // ADC FIFO model: registered read, data one cycle after pop
  always @(posedge clk) begin
    if (adc_pop) begin
      adc_sample <= adc_model(adc_idx);
      adc_idx    <= adc_idx + 1;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int base, a_base;
    logic [47:0] m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 strobes", {dac_strobe, adc_strobe}, 2'b00);
    chk("R8 irqs", {dac_irq, adc_irq}, 2'b00);
    chk("R8 commit/pop", {dac_commit, adc_pop}, 2'b00);
    chk("R8 rd_data", rd_data, 16'h0);
    @(posedge clk); #1;

    // R1 ignored control addresses leave DAC disabled
    a_base = adc_stb_cnt;
    ctrl(8'd0, 8'hFF);
    ctrl(8'h81, 8'h01);
    ctrl(8'd5, 8'h01);
    base = dac_stb_cnt;
    ticks(3);
    chk("R1 ignored addr no dac strobe", 64'(dac_stb_cnt - base), 64'd0);
    wr(3'd5, 16'd16);
    dac_level = 8'd3;
    repeat (2) @(posedge clk); #1;
    chk("R1/R3 dac irq while disabled", dac_irq, 1'b0);

    // R2 rates
    dac_rate(4'd0, 5, 5);
    dac_rate(4'd1, 7, 3);
    dac_rate(4'd2, 9, 3);
    dac_rate(4'd15, 33, 2);
    chk("R3 adc quiet while disabled", 64'(adc_stb_cnt - a_base), 64'd0);

    // ADC rate n=3
    ctrl(8'd4, 8'h03);
    ctrl(8'd3, 8'h01);
    base = adc_stb_cnt;
    ticks(10);
    chk("R2 adc n=3", 64'(adc_stb_cnt - base), 64'd2);

    // R4 DAC threshold (DAC enabled, thr 16)
    dac_level = 8'd15; repeat (2) @(posedge clk); #1;
    chk("R4 dac below", dac_irq, 1'b1);
    dac_level = 8'd16; repeat (2) @(posedge clk); #1;
    chk("R4 dac equal", dac_irq, 1'b0);
    dac_level = 8'd17; repeat (2) @(posedge clk); #1;
    chk("R4 dac above", dac_irq, 1'b0);
    dac_level = 8'd0; repeat (2) @(posedge clk); #1;
    chk("R4 dac empty", dac_irq, 1'b1);
    ctrl(8'd1, 8'd0);
    repeat (2) @(posedge clk); #1;
    chk("R3 dac irq off when disabled", dac_irq, 1'b0);
    base = dac_stb_cnt;
    ticks(4);
    chk("R3 dac no strobe disabled", 64'(dac_stb_cnt - base), 64'd0);

    // R5 ADC threshold (ADC enabled, thr 200)
    wr(3'd6, 16'd200);
    adc_level = 8'd201; repeat (2) @(posedge clk); #1;
    chk("R5 adc above", adc_irq, 1'b1);
    adc_level = 8'd200; repeat (2) @(posedge clk); #1;
    chk("R5 adc equal", adc_irq, 1'b0);
    adc_level = 8'd10; repeat (2) @(posedge clk); #1;
    chk("R5 adc below", adc_irq, 1'b0);
    adc_level = 8'd255;
    ctrl(8'd3, 8'd0);
    repeat (2) @(posedge clk); #1;
    chk("R3 adc irq off when disabled", adc_irq, 1'b0);

    // R6 DAC commits through scoreboard
    dac_send(24'h123456, 24'hABCDEF);
    dac_send(24'hFF00A5, 24'h00FF5A);
    dac_send(24'h000001, 24'h800000);
    repeat (3) @(posedge clk); #1;
    chk("R6 all commits seen", 64'(exp_q.size()), 64'd0);
    wr(3'd0, 16'hDEAD);
    wr(3'd2, 16'hBEEF);
    repeat (2) @(posedge clk); #1;
    chk("R6 sample unchanged w/o commit", 64'(dac_sample), 64'h000001800000);

    // R7 ADC pop and read-back timing
    for (int k = 0; k < 3; k++) begin
      m = adc_model(k);
      wr(3'd7, 16'h0);
      chk("R7 pop pulse", adc_pop, 1'b1);
      rd_sel = 2'd0;
      @(posedge clk); #1;
      chk("R7 pop single", adc_pop, 1'b0);
      if (k > 0) begin
        m = adc_model(k - 1);
        chk("R7 old data one cycle after", rd_data, m[47:32]);
        m = adc_model(k);
      end
      @(posedge clk); #1;
      rd_sel = 2'd0; #1 chk("R7 left high", rd_data, m[47:32]);
      rd_sel = 2'd1; #1 chk("R7 left low", rd_data, {8'h00, m[31:24]});
      rd_sel = 2'd2; #1 chk("R7 right high", rd_data, m[23:8]);
      rd_sel = 2'd3; #1 chk("R7 right low", rd_data, {8'h00, m[7:0]});
    end

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule